// File: doc/BRIEF.md
# I2C Bus Status and Mode Controller

This block keeps the eight-bit status and mode word of an I2C controller that can work as either master or slave. It watches the bus lines through synchronizers, finds START and STOP conditions, and from them keeps a bus-busy flag. It holds the master and transmit mode bits that software writes. It drops master mode by itself when arbitration is lost, when a STOP is seen, or when its own START request is refused.

A separate byte engine does the shifting and clock division. It reports to this block through one-cycle strobes: byte complete, arbitration lost, address matched, received byte and received bit. This block turns those strobes into read-only flags and an active-low interrupt-pending bit. When the block asks for a START, it raises a start-generate pulse and a bit-counter reset pulse. It enables its SCL driver only after that START has been granted. A guard refuses the request when another master already holds the bus.

Top module: `ibs_status_ctrl`

## Requirements
- R1: After reset the status word reads 0x10: only the interrupt-pending bit (bit 4) is 1. `start_gen`, `bitcnt_rst` and `scl_drive_en` are 0.
- R2: A write sets MST (bit 7) and TRX (bit 6) from `wr_data[7:6]` on the next cycle. The pair {MST,TRX} reads 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R3: A START (SDA falls while SCL is high) sets bus-busy (bit 5) within six cycles. A STOP (SDA rises while SCL is high) clears it within six cycles.
- R4: A detected STOP clears MST, and this takes priority over a write in the same cycle.
- R5: Interrupt-pending (bit 4) is active low. A `byte_done` strobe drives it to 0. A write with `wr_data[4]`=1 returns it to 1. A write with `wr_data[4]`=0 leaves it unchanged. `byte_done` wins over a write in the same cycle.
- R6: An `arb_lost` strobe sets the arbitration-lost flag (bit 3). MST stays 1 until the next `byte_done` and is 0 on the cycle after it. A write with `wr_data[7]`=1 clears the flag, unless `arb_lost` arrives in the same cycle.
- R7: Writes do not change bits 0 to 3 or bit 5.
- R8: If `start_req` arrives while MST is 1 and the bus is free, `start_gen` and `bitcnt_rst` are 1 for exactly one cycle, starting the next cycle. `scl_drive_en` then stays 1 while MST is 1 and until a STOP. If `start_req` arrives while MST is 0, it produces no pulse.
- R9: If `start_req` arrives while MST is 1, the bus is busy and this device did not issue the START that made it busy, the request is refused. On the next cycle `start_gen`, `bitcnt_rst` and `scl_drive_en` are 0 and MST is 0.
- R10: The general-call flag (bit 1) is set when the first received byte after a START equals 0x00 while MST is 0. It stays 0 for a nonzero byte or when MST is 1. A START or STOP clears it.
- R11: An `addr_match` strobe sets the address-match flag (bit 2). A START or STOP clears it.
- R12: Each `rx_bit_valid` strobe copies `rx_bit` into the last-received-bit flag (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| wr_en | input | 1 | Software write strobe for the status word |
| wr_data | input | 8 | Write data; only bits 7, 6 and 4 have an effect |
| start_req | input | 1 | Request to generate a START |
| byte_done | input | 1 | Byte-complete strobe from the byte engine |
| arb_lost | input | 1 | Arbitration-lost strobe from the byte engine |
| addr_match | input | 1 | Slave address match strobe |
| rx_byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte value |
| rx_bit_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received bit value |
| status | output | 8 | {MST,TRX,busy,irq_n,AL,addr_match,gen_call,last_bit} |
| start_gen | output | 1 | One-cycle pulse: generate START |
| bitcnt_rst | output | 1 | One-cycle pulse: reset the bit counter |
| scl_drive_en | output | 1 | Permission to drive the clock on SCL |

## Verification
The hardest case to reach is the refused START. The bus must already be busy because of another master's START, and this device must be in master mode without having issued that START, when its own request arrives. The stimulus produces the condition directly. It drives a START onto the modelled SDA and SCL lines, sets MST by a write while the bus stays busy, and then issues `start_req`. It then checks that no pulses follow and that MST has dropped. Arbitration loss followed by byte completion, and clear-versus-write collisions, are reached by random strobes checked every cycle against a bench model.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
   localparam int STAT_W = 8;
   localparam int B_LRB  = 0;
   localparam int B_GC   = 1;
   localparam int B_AAS  = 2;
   localparam int B_AL   = 3;
   localparam int B_PIN  = 4;
   localparam int B_BB   = 5;
   localparam int B_TRX  = 6;
   localparam int B_MST  = 7;

   typedef enum logic [1:0] {
      MODE_SLV_RX = 2'b00,
      MODE_SLV_TX = 2'b01,
      MODE_MST_RX = 2'b10,
      MODE_MST_TX = 2'b11
   } ibs_mode_e;
endpackage

// File: rtl/ibs_sync.sv
module ibs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ibs_cond_det.sv
module ibs_cond_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic start_det,
   output logic stop_det,
   output logic bus_busy
);
   localparam int LINES = 2;

   logic [LINES-1:0] raw, synced;
   logic             scl_p, sda_p;

   assign raw = {scl_in, sda_in};

   for (genvar g = 0; g < LINES; g++) begin : g_sync
      ibs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw[g]),
         .q     (synced[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p    <= 1'b1;
         sda_p    <= 1'b1;
         bus_busy <= 1'b0;
      end else begin
         scl_p <= synced[1];
         sda_p <= synced[0];
         if (stop_det)       bus_busy <= 1'b0;
         else if (start_det) bus_busy <= 1'b1;
      end
   end

   assign start_det = synced[1] & scl_p & sda_p & ~synced[0];
   assign stop_det  = synced[1] & scl_p & ~sda_p & synced[0];
endmodule

// File: rtl/ibs_mode_ctl.sv
module ibs_mode_ctl #(
   parameter bit GUARD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_mst,
   input  logic wr_trx,
   input  logic start_req,
   input  logic stop_det,
   input  logic bus_busy,
   input  logic byte_done,
   input  logic arb_pend,
   output logic mst,
   output logic trx,
   output logic start_gen,
   output logic bitcnt_rst,
   output logic scl_drive_en,
   output logic guard_block
);
   logic own_bus;
   logic issue;
   logic mst_clr;

   if (GUARD_EN) begin : g_guard
      assign guard_block = start_req & mst & bus_busy & ~own_bus;
   end else begin : g_noguard
      assign guard_block = 1'b0;
   end

   assign issue   = start_req & mst & ~guard_block;
   assign mst_clr = stop_det | guard_block | (byte_done & arb_pend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst        <= 1'b0;
         trx        <= 1'b0;
         start_gen  <= 1'b0;
         bitcnt_rst <= 1'b0;
         own_bus    <= 1'b0;
      end else begin
         start_gen  <= issue;
         bitcnt_rst <= issue;
         if (stop_det)   own_bus <= 1'b0;
         else if (issue) own_bus <= 1'b1;
         if (mst_clr)    mst <= 1'b0;
         else if (wr_en) mst <= wr_mst;
         if (wr_en)      trx <= wr_trx;
      end
   end

   assign scl_drive_en = mst & own_bus;
endmodule

// File: rtl/ibs_flags.sv
module ibs_flags #(
   parameter int BYTE_W  = 8,
   parameter int GC_CODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_pin,
   input  logic              wr_mst,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              mst,
   input  logic              byte_done,
   input  logic              arb_lost,
   input  logic              addr_match,
   input  logic              rx_byte_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_bit_valid,
   input  logic              rx_bit,
   output logic              al,
   output logic              aas,
   output logic              gc,
   output logic              lrb,
   output logic              pin_n
);
   localparam logic [BYTE_W-1:0] GC_VAL = BYTE_W'(GC_CODE);

   logic first_byte;
   logic cond_seen;

   assign cond_seen = start_det | stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al         <= 1'b0;
         aas        <= 1'b0;
         gc         <= 1'b0;
         lrb        <= 1'b0;
         pin_n      <= 1'b1;
         first_byte <= 1'b0;
      end else begin
         if (arb_lost)              al <= 1'b1;
         else if (wr_en && wr_mst)  al <= 1'b0;

         if (cond_seen)             aas <= 1'b0;
         else if (addr_match)       aas <= 1'b1;

         if (cond_seen)             gc <= 1'b0;
         else if (rx_byte_valid && first_byte && !mst && rx_byte == GC_VAL)
                                    gc <= 1'b1;

         if (start_det)             first_byte <= 1'b1;
         else if (stop_det || rx_byte_valid) first_byte <= 1'b0;

         if (rx_bit_valid)          lrb <= rx_bit;

         if (byte_done)             pin_n <= 1'b0;
         else if (wr_en && wr_pin)  pin_n <= 1'b1;
      end
   end
endmodule

// File: rtl/ibs_status_ctrl.sv
module ibs_status_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter bit GUARD_EN    = 1'b1,
   parameter int BYTE_W      = 8,
   parameter int GC_CODE     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              start_req,
   input  logic              byte_done,
   input  logic              arb_lost,
   input  logic              addr_match,
   input  logic              rx_byte_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_bit_valid,
   input  logic              rx_bit,
   output logic [7:0]        status,
   output logic              start_gen,
   output logic              bitcnt_rst,
   output logic              scl_drive_en
);
   import ibs_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GC_CODE < 0 || GC_CODE >= (1 << BYTE_W)) begin : g_bad_gc
      $error("GC_CODE must fit in BYTE_W bits");
   end

   logic start_det, stop_det, bus_busy;
   logic mst, trx, guard_block;
   logic al, aas, gc, lrb, pin_n;

   ibs_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .start_det (start_det),
      .stop_det  (stop_det),
      .bus_busy  (bus_busy)
   );

   ibs_mode_ctl #(.GUARD_EN(GUARD_EN)) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_mst       (wr_data[B_MST]),
      .wr_trx       (wr_data[B_TRX]),
      .start_req    (start_req),
      .stop_det     (stop_det),
      .bus_busy     (bus_busy),
      .byte_done    (byte_done),
      .arb_pend     (al | arb_lost),
      .mst          (mst),
      .trx          (trx),
      .start_gen    (start_gen),
      .bitcnt_rst   (bitcnt_rst),
      .scl_drive_en (scl_drive_en),
      .guard_block  (guard_block)
   );

   ibs_flags #(.BYTE_W(BYTE_W), .GC_CODE(GC_CODE)) u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_pin        (wr_data[B_PIN]),
      .wr_mst        (wr_data[B_MST]),
      .start_det     (start_det),
      .stop_det      (stop_det),
      .mst           (mst),
      .byte_done     (byte_done),
      .arb_lost      (arb_lost),
      .addr_match    (addr_match),
      .rx_byte_valid (rx_byte_valid),
      .rx_byte       (rx_byte),
      .rx_bit_valid  (rx_bit_valid),
      .rx_bit        (rx_bit),
      .al            (al),
      .aas           (aas),
      .gc            (gc),
      .lrb           (lrb),
      .pin_n         (pin_n)
   );

   always_comb begin
      status        = '0;
      status[B_MST] = mst;
      status[B_TRX] = trx;
      status[B_BB]  = bus_busy;
      status[B_PIN] = pin_n;
      status[B_AL]  = al;
      status[B_AAS] = aas;
      status[B_GC]  = gc;
      status[B_LRB] = lrb;
   end
endmodule

// File: rtl/ibs_status_ctrl_chk.sv
module ibs_status_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] status,
   input logic       start_gen,
   input logic       bitcnt_rst,
   input logic       scl_drive_en,
   input logic       start_det,
   input logic       stop_det,
   input logic       byte_done,
   input logic       guard_block
);
   AST_STOP_CLEARS_MST: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !status[7]); // R4
   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> status[5]); // R3
   AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !status[5]); // R3
   AST_BYTE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !status[4]); // R5
   AST_ARB_DROPS_MST: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && status[3]) |=> !status[7]); // R6
   AST_GUARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      guard_block |=> (!start_gen && !bitcnt_rst && !status[7] && !scl_drive_en)); // R9
   AST_SCL_NEEDS_MST: assert property (@(posedge clk) disable iff (!rst_n)
      scl_drive_en |-> status[7]); // R8
endmodule

bind ibs_status_ctrl ibs_status_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .status       (status),
   .start_gen    (start_gen),
   .bitcnt_rst   (bitcnt_rst),
   .scl_drive_en (scl_drive_en),
   .start_det    (start_det),
   .stop_det     (stop_det),
   .byte_done    (byte_done),
   .guard_block  (guard_block)
);

// File: tb/ibs_status_ctrl_bench.sv
`timescale 1ns/1ps
module ibs_status_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       start_req = 1'b0, byte_done = 1'b0, arb_lost = 1'b0, addr_match = 1'b0;
   logic       rx_byte_valid = 1'b0, rx_bit_valid = 1'b0, rx_bit = 1'b0;
   logic [7:0] rx_byte = '0;
   logic [7:0] status;
   logic       start_gen, bitcnt_rst, scl_drive_en;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ibs_status_ctrl u_ibs_status_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .wr_en(wr_en), .wr_data(wr_data), .start_req(start_req),
      .byte_done(byte_done), .arb_lost(arb_lost), .addr_match(addr_match),
      .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
      .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
      .status(status), .start_gen(start_gen), .bitcnt_rst(bitcnt_rst),
      .scl_drive_en(scl_drive_en));

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] pack(input logic m, t, b, p, a, s, g, l);
      return {m, t, b, p, a, s, g, l};
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_in();
      wr_en = 0; start_req = 0; byte_done = 0; arb_lost = 0; addr_match = 0;
      rx_byte_valid = 0; rx_bit_valid = 0;
   endtask

   task automatic write(input logic [7:0] d);
      wr_en = 1; wr_data = d; cyc(1); wr_en = 0;
   endtask

   task automatic bus_start();
      scl_in = 1; sda_in = 0; cyc(6); scl_in = 0; cyc(2);
   endtask

   task automatic bus_stop();
      scl_in = 0; sda_in = 0; cyc(2); scl_in = 1; cyc(3); sda_in = 1; cyc(6);
   endtask

   task automatic do_reset();
      rst_n = 0; cyc(3); rst_n = 1; cyc(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic m, t, p, a, s, l;
      void'($urandom(32'h1C5EED));
      @(negedge clk); cyc(2);
      rst_n = 1; cyc(1);
      // R1 reset state
      chk("R1 status", status, 8'h10);
      chk("R1 pulses", {5'b0, start_gen, bitcnt_rst, scl_drive_en}, 8'h00);

      // Random phase, bus idle; R5 R6 R2 R11 R12 model
      m = 0; t = 0; p = 1; a = 0; s = 0; l = 0;
      for (int i = 0; i < 400; i++) begin
         logic w, bd, ar, am, rv, rb;
         logic [7:0] d;
         w  = ($urandom % 6) == 0;
         bd = ($urandom % 8) == 0;
         ar = ($urandom % 10) == 0;
         am = ($urandom % 12) == 0;
         rv = ($urandom % 3) == 0;
         rb = $urandom % 2;
         d  = 8'($urandom);
         wr_en = w; wr_data = d; byte_done = bd; arb_lost = ar;
         addr_match = am; rx_bit_valid = rv; rx_bit = rb;
         if (bd && (a || ar)) m = 0; else if (w) m = d[7];
         if (w) t = d[6];
         if (bd) p = 0; else if (w && d[4]) p = 1;
         if (ar) a = 1; else if (w && d[7]) a = 0;
         if (am) s = 1;
         if (rv) l = rb;
         cyc(1);
         chk("R5 R6 R12 random status", status, pack(m, t, 1'b0, p, a, s, 1'b0, l));
         chk("R8 random no start", {6'b0, start_gen, scl_drive_en}, 8'h00);
      end
      clear_in();
      do_reset();

      // R2 mode encodings
      write(8'hC0); chk("R2 master tx", {6'b0, status[7:6]}, 8'h03);
      write(8'h80); chk("R2 master rx", {6'b0, status[7:6]}, 8'h02);
      write(8'h40); chk("R2 slave tx",  {6'b0, status[7:6]}, 8'h01);
      write(8'h00); chk("R2 slave rx",  {6'b0, status[7:6]}, 8'h00);
      // R7 read-only bits
      write(8'h2F); chk("R7 ro bits", status, 8'h10);

      // R8 start_req with MST=0 ignored
      start_req = 1; cyc(1); start_req = 0;
      chk("R8 no pulse when slave", {6'b0, start_gen, bitcnt_rst}, 8'h00);

      // Slave transaction: R3 R10 R11 R4
      bus_start();
      chk("R3 busy after start", {7'b0, status[5]}, 8'h01);
      rx_byte = 8'h00; rx_byte_valid = 1; cyc(1); rx_byte_valid = 0;
      chk("R10 general call", {7'b0, status[1]}, 8'h01);
      addr_match = 1; cyc(1); addr_match = 0;
      chk("R11 addr match", {7'b0, status[2]}, 8'h01);
      rx_byte = 8'h00; rx_byte_valid = 1; cyc(1); rx_byte_valid = 0;
      chk("R10 second byte keeps", {7'b0, status[1]}, 8'h01);
      write(8'h80);
      bus_stop();
      chk("R3 R4 R10 R11 after stop", status, 8'h10);

      // Nonzero first byte: no general call
      bus_start();
      rx_byte = 8'h5A; rx_byte_valid = 1; cyc(1); rx_byte_valid = 0;
      rx_byte = 8'h00; rx_byte_valid = 1; cyc(1); rx_byte_valid = 0;
      chk("R10 nonzero first byte", {7'b0, status[1]}, 8'h00);
      bus_stop();

      // Master path: R8 R6 R5 R10
      write(8'h80);
      start_req = 1; cyc(1); start_req = 0;
      chk("R8 pulse", {5'b0, start_gen, bitcnt_rst, scl_drive_en}, 8'h07);
      cyc(1);
      chk("R8 pulse one cycle", {5'b0, start_gen, bitcnt_rst, scl_drive_en}, 8'h01);
      bus_start();
      rx_byte = 8'h00; rx_byte_valid = 1; cyc(1); rx_byte_valid = 0;
      chk("R10 no gc as master", {7'b0, status[1]}, 8'h00);
      arb_lost = 1; cyc(1); arb_lost = 0;
      chk("R6 AL set MST kept", {6'b0, status[7], status[3]}, 8'h03);
      byte_done = 1; cyc(1); byte_done = 0;
      chk("R6 R5 MST drop irq", {5'b0, status[7], status[4], scl_drive_en}, 8'h00);
      write(8'h00);
      chk("R5 write 0 keeps irq", {7'b0, status[4]}, 8'h00);
      write(8'h90);
      chk("R5 R6 irq release AL clear", status & 8'h98, 8'h90);
      bus_stop();
      chk("R4 stop clears MST", {7'b0, status[7]}, 8'h00);

      // Guard: R9
      bus_start();
      write(8'h80);
      start_req = 1; cyc(1); start_req = 0;
      chk("R9 refused start", {4'b0, status[7], start_gen, bitcnt_rst, scl_drive_en}, 8'h00);
      bus_stop();
      chk("R3 free after guard", {7'b0, status[5]}, 8'h00);

      // R12 directed
      rx_bit = 1; rx_bit_valid = 1; cyc(1); rx_bit_valid = 0;
      chk("R12 last bit 1", {7'b0, status[0]}, 8'h01);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule